// File: doc/BRIEF.md
# Memory Presence-Detect Configuration Decoder

This block turns the 64-byte configuration record of a synchronous DRAM module into the settings a memory controller needs. The record arrives as a stream. Each beat carries one byte and that byte's position in the record. While the stream runs, the block captures the geometry fields and the timing fields. It keeps a running 8-bit sum of the record, clamps geometry values that are out of range, and turns the refresh-rate code into a tick count. It picks a CAS latency from the supported-latency mask and computes the size exponent of one chip-select.

The decoded configuration appears on registered outputs once the last byte has been accepted. A one-cycle done pulse marks that moment. The outputs then hold their values until a byte at position 0 starts a new record.

The input is valid/ready. The block never applies back-pressure. `in_ready` is low during reset and goes high on the first clock after reset is released. It then stays high, so every beat with `in_valid` high is consumed in the cycle it is presented.

Top module: `spd_cfg_decoder`

## Requirements
- R1: `in_ready` is 0 while reset is held and becomes 1 on the first clock edge after reset is released. It stays 1 from then on. A beat is accepted on each edge where both `in_valid` and `in_ready` are 1.
- R2: The row count is the low 4 bits of byte 3, and values above 14 are reported as 14. The column count is the low 4 bits of byte 4, and values above 11 are reported as 11.
- R3: The chip-select count is the low 4 bits of byte 5.
- R4: The data width is a 16-bit value: byte 6 is its low byte and byte 7 its high byte. `width_warn` is 1 exactly when this width is neither 64 nor 72.
- R5: Bits 6..0 of byte 12 select the refresh tick count: code 0 gives 14, 1 gives 2, 2 gives 6, 3 gives 29, 4 gives 60 and 5 gives 120. Every other code gives 14.
- R6: Byte 17 holds the bank count. A value of 2 is reported as 1, 4 as 2 and 8 as 3. Any other value is reported unchanged.
- R7: The CAS latency comes from byte 18. If bit 0 is set the latency is 1. Otherwise, if bit 1 is set it is 2. Otherwise it is 3. A result below 2 is raised to 2. If byte 18 was not received since the last restart, the reported latency is 2.
- R8: `cksum_err` is 1 when the 8-bit wrapping sum of bytes 0 through 62 differs from byte 63.
- R9: The size exponent is the reported row count plus the reported column count plus the reported bank value plus 3.
- R10: Accepting byte 63 drives `done` high for exactly one cycle. All configuration outputs update on that same edge and hold their values until the next restart.
- R11: Accepting byte 0 clears every configuration output and both flags on that edge. A record that never delivers byte 63 produces no `done` pulse, and the outputs stay cleared.
- R12: After reset, every configuration output, both flags and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Beat present |
| in_ready | output | 1 | Beat can be accepted |
| in_index | input | 6 | Position of the byte in the record |
| in_byte | input | 8 | Record byte |
| row_bits | output | 4 | Row address bits, clamped |
| col_bits | output | 4 | Column address bits, clamped |
| bank_log2 | output | 8 | Converted bank value |
| cs_count | output | 4 | Chip-select count |
| data_width | output | 16 | Module data width |
| refresh_ticks | output | 7 | Refresh interval in ticks |
| cas_latency | output | 2 | Selected CAS latency |
| size_exp | output | 9 | log2 of the bytes per chip-select |
| cksum_err | output | 1 | Record checksum mismatch |
| width_warn | output | 1 | Data width neither 64 nor 72 |
| done | output | 1 | One-cycle pulse after byte 63 is accepted |

## Verification
The assertions assume that each record starts at position 0 and that positions then rise. They also assume that no position is repeated between a restart and byte 63. A repeated byte would be added into the checksum twice. The stimulus always sends positions in ascending order from 0, with idle cycles at irregular places. It cuts one record short to exercise R11. It never revisits a position inside a record, and it keeps `in_valid` at 0 while reset is held.

// File: rtl/spd_pkg.sv
package spd_pkg;
  // Byte positions inside the record (the decode depends on them)
  localparam int unsigned POS_ROWS  = 3;
  localparam int unsigned POS_COLS  = 4;
  localparam int unsigned POS_CS    = 5;
  localparam int unsigned POS_WLO   = 6;
  localparam int unsigned POS_WHI   = 7;
  localparam int unsigned POS_RFSH  = 12;
  localparam int unsigned POS_BANKS = 17;
  localparam int unsigned POS_CAS   = 18;

  localparam int unsigned ROW_MAX = 14;
  localparam int unsigned COL_MAX = 11;
  localparam int unsigned BUS_LOG2 = 3;

  typedef struct packed {
    logic [3:0]  rows;
    logic [3:0]  cols;
    logic [3:0]  cs;
    logic [15:0] width;
    logic [6:0]  rfsh_code;
    logic [7:0]  banks;
    logic [1:0]  cas;
  } spd_raw_t;

  typedef struct packed {
    logic [3:0]  rows;
    logic [3:0]  cols;
    logic [7:0]  bank_log2;
    logic [3:0]  cs;
    logic [15:0] width;
    logic [6:0]  rfsh_ticks;
    logic [1:0]  cas;
    logic [8:0]  size_exp;
    logic        cksum_err;
    logic        width_warn;
  } spd_cfg_t;
endpackage

// File: rtl/spd_capture.sv
module spd_capture
  import spd_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       data,
  output spd_raw_t         raw
);
  spd_raw_t raw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
    end else if (acc) begin
      if (idx == '0) begin
        raw_q <= '0;
      end else if (idx == IDX_W'(POS_ROWS)) begin
        raw_q.rows <= data[3:0];
      end else if (idx == IDX_W'(POS_COLS)) begin
        raw_q.cols <= data[3:0];
      end else if (idx == IDX_W'(POS_CS)) begin
        raw_q.cs <= data[3:0];
      end else if (idx == IDX_W'(POS_WLO)) begin
        raw_q.width[7:0] <= data;
      end else if (idx == IDX_W'(POS_WHI)) begin
        raw_q.width[15:8] <= data;
      end else if (idx == IDX_W'(POS_RFSH)) begin
        raw_q.rfsh_code <= data[6:0];
      end else if (idx == IDX_W'(POS_BANKS)) begin
        raw_q.banks <= data;
      end else if (idx == IDX_W'(POS_CAS)) begin
        // lowest supported latency wins; an empty mask falls back to 3
        if (data[0])      raw_q.cas <= 2'd1;
        else if (data[1]) raw_q.cas <= 2'd2;
        else              raw_q.cas <= 2'd3;
      end
    end
  end

  assign raw = raw_q;

  // R7: a captured mask always yields a latency in 1..3
  assert_cas_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && idx == IDX_W'(POS_CAS)) |=> (raw_q.cas != 2'd0));
endmodule

// File: rtl/spd_checksum.sv
module spd_checksum #(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned LAST  = 63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       data,
  output logic [7:0]       sum
);
  logic [7:0] sum_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else if (acc) begin
      if (idx == '0)                  sum_q <= data;
      else if (idx < IDX_W'(LAST))    sum_q <= sum_q + data;
    end
  end

  assign sum = sum_q;

  // R8: a restart seeds the running sum with byte 0 alone
  assert_sum_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && idx == '0) |=> (sum_q == $past(data)));
  // R8: the checksum byte itself never enters the sum
  assert_sum_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && idx == IDX_W'(LAST)) |=> (sum_q == $past(sum_q)));
endmodule

// File: rtl/spd_resolve.sv
module spd_resolve
  import spd_pkg::*;
(
  input  spd_raw_t raw,
  output spd_cfg_t cfg
);
  logic [3:0] rows_c, cols_c;
  logic [7:0] bank_c;
  logic [6:0] ticks_c;
  logic [1:0] cas_c;

  always_comb begin
    rows_c = (raw.rows > 4'(ROW_MAX)) ? 4'(ROW_MAX) : raw.rows;
    cols_c = (raw.cols > 4'(COL_MAX)) ? 4'(COL_MAX) : raw.cols;

    case (raw.banks)
      8'd2:    bank_c = 8'd1;
      8'd4:    bank_c = 8'd2;
      8'd8:    bank_c = 8'd3;
      default: bank_c = raw.banks;
    endcase

    case (raw.rfsh_code)
      7'd1:    ticks_c = 7'd2;
      7'd2:    ticks_c = 7'd6;
      7'd3:    ticks_c = 7'd29;
      7'd4:    ticks_c = 7'd60;
      7'd5:    ticks_c = 7'd120;
      default: ticks_c = 7'd14;
    endcase

    cas_c = (raw.cas < 2'd2) ? 2'd2 : raw.cas;

    cfg            = '0;
    cfg.rows       = rows_c;
    cfg.cols       = cols_c;
    cfg.bank_log2  = bank_c;
    cfg.cs         = raw.cs;
    cfg.width      = raw.width;
    cfg.rfsh_ticks = ticks_c;
    cfg.cas        = cas_c;
    cfg.size_exp   = 9'(rows_c) + 9'(cols_c) + 9'(bank_c) + 9'(BUS_LOG2);
    cfg.width_warn = (raw.width != 16'd64) && (raw.width != 16'd72);
    cfg.cksum_err  = 1'b0;
  end
endmodule

// File: rtl/spd_cfg_decoder.sv
module spd_cfg_decoder
  import spd_pkg::*;
#(
  parameter int unsigned NUM_BYTES = 64,
  localparam int unsigned IDX_W = $clog2(NUM_BYTES),
  localparam int unsigned LAST  = NUM_BYTES - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IDX_W-1:0] in_index,
  input  logic [7:0]       in_byte,
  output logic [3:0]       row_bits,
  output logic [3:0]       col_bits,
  output logic [7:0]       bank_log2,
  output logic [3:0]       cs_count,
  output logic [15:0]      data_width,
  output logic [6:0]       refresh_ticks,
  output logic [1:0]       cas_latency,
  output logic [8:0]       size_exp,
  output logic             cksum_err,
  output logic             width_warn,
  output logic             done
);
  logic       ready_q, done_q, acc;
  spd_raw_t   raw;
  spd_cfg_t   resolved, cfg_q;
  logic [7:0] sum;

  assign acc = in_valid && ready_q;

  spd_capture #(.IDX_W(IDX_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .acc(acc), .idx(in_index), .data(in_byte), .raw(raw)
  );

  spd_checksum #(.IDX_W(IDX_W), .LAST(LAST)) u_checksum (
    .clk(clk), .rst_n(rst_n), .acc(acc), .idx(in_index), .data(in_byte), .sum(sum)
  );

  spd_resolve u_resolve (.raw(raw), .cfg(resolved));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      done_q  <= 1'b0;
      cfg_q   <= '0;
    end else begin
      ready_q <= 1'b1;
      done_q  <= acc && (in_index == IDX_W'(LAST));
      if (acc && in_index == '0) begin
        cfg_q <= '0;
      end else if (acc && in_index == IDX_W'(LAST)) begin
        cfg_q           <= resolved;
        cfg_q.cksum_err <= (sum != in_byte);
      end
    end
  end

  assign in_ready      = ready_q;
  assign done          = done_q;
  assign row_bits      = cfg_q.rows;
  assign col_bits      = cfg_q.cols;
  assign bank_log2     = cfg_q.bank_log2;
  assign cs_count      = cfg_q.cs;
  assign data_width    = cfg_q.width;
  assign refresh_ticks = cfg_q.rfsh_ticks;
  assign cas_latency   = cfg_q.cas;
  assign size_exp      = cfg_q.size_exp;
  assign cksum_err     = cfg_q.cksum_err;
  assign width_warn    = cfg_q.width_warn;

  assert_ready_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ready_q) |-> ready_q);
  assert_clamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (row_bits <= 4'(ROW_MAX)) && (col_bits <= 4'(COL_MAX)));
  assert_refresh_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (refresh_ticks == 7'd14 || refresh_ticks == 7'd2 || refresh_ticks == 7'd6 ||
              refresh_ticks == 7'd29 || refresh_ticks == 7'd60 || refresh_ticks == 7'd120));
  assert_cas_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cas_latency >= 2'd2));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_index == IDX_W'(LAST)) |=> done);
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_outputs_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && (in_index == '0 || in_index == IDX_W'(LAST))) |=> $stable(cfg_q));
  assert_restart_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_index == '0) |=> (!cksum_err && !width_warn && !done && size_exp == '0));
endmodule

// File: tb/spd_cfg_decoder_tb_top.sv
module spd_cfg_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [5:0] in_index = '0;
  logic [7:0] in_byte = '0;
  logic [3:0] row_bits, col_bits, cs_count;
  logic [7:0] bank_log2;
  logic [15:0] data_width;
  logic [6:0] refresh_ticks;
  logic [1:0] cas_latency;
  logic [8:0] size_exp;
  logic cksum_err, width_warn, done;

  always #2.5 clk = ~clk;

  spd_cfg_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_index(in_index), .in_byte(in_byte), .row_bits(row_bits), .col_bits(col_bits),
    .bank_log2(bank_log2), .cs_count(cs_count), .data_width(data_width),
    .refresh_ticks(refresh_ticks), .cas_latency(cas_latency), .size_exp(size_exp),
    .cksum_err(cksum_err), .width_warn(width_warn), .done(done)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  bit started = 0;

  // ---------------- behavioural reference model ----------------
  int mem [64];
  bit got_cas;
  int e_ready = 0, e_done = 0, e_rows = 0, e_cols = 0, e_bank = 0, e_cs = 0;
  int e_width = 0, e_ticks = 0, e_cas = 0, e_size = 0, e_err = 0, e_warn = 0;

  task automatic model_clear();
    e_rows = 0; e_cols = 0; e_bank = 0; e_cs = 0; e_width = 0;
    e_ticks = 0; e_cas = 0; e_size = 0; e_err = 0; e_warn = 0;
  endtask

  task automatic model_finish();
    int code, s;
    e_rows = mem[3] & 15;  if (e_rows > 14) e_rows = 14;
    e_cols = mem[4] & 15;  if (e_cols > 11) e_cols = 11;
    e_cs = mem[5] & 15;
    e_width = mem[6] + mem[7] * 256;
    e_warn = (e_width != 64 && e_width != 72) ? 1 : 0;
    code = mem[12] & 127;
    case (code)
      1: e_ticks = 2;  2: e_ticks = 6;  3: e_ticks = 29;
      4: e_ticks = 60; 5: e_ticks = 120; default: e_ticks = 14;
    endcase
    e_bank = mem[17];
    if (e_bank == 2) e_bank = 1; else if (e_bank == 4) e_bank = 2; else if (e_bank == 8) e_bank = 3;
    if (!got_cas) e_cas = 0;
    else if (mem[18] & 1) e_cas = 1;
    else if (mem[18] & 2) e_cas = 2;
    else e_cas = 3;
    if (e_cas < 2) e_cas = 2;
    e_size = e_rows + e_cols + e_bank + 3;
    s = 0;
    for (int i = 0; i < 63; i++) s += mem[i];
    e_err = ((s & 255) != mem[63]) ? 1 : 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      e_ready = 0; e_done = 0; model_clear();
    end else begin
      e_done = 0;
      if (in_valid && e_ready == 1) begin
        if (in_index == 0) begin
          for (int i = 0; i < 64; i++) mem[i] = 0;
          got_cas = 0;
          model_clear();
        end
        mem[in_index] = in_byte;
        if (in_index == 18) got_cas = 1;
        if (in_index == 63) begin model_finish(); e_done = 1; end
      end
      e_ready = 1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      vectors++;
      chk("R1 in_ready", in_ready, e_ready);
      chk("R2 row_bits", row_bits, e_rows);
      chk("R2 col_bits", col_bits, e_cols);
      chk("R3 cs_count", cs_count, e_cs);
      chk("R4 data_width", data_width, e_width);
      chk("R4 width_warn", width_warn, e_warn);
      chk("R5 refresh_ticks", refresh_ticks, e_ticks);
      chk("R6 bank_log2", bank_log2, e_bank);
      chk("R7 cas_latency", cas_latency, e_cas);
      chk("R8 cksum_err", cksum_err, e_err);
      chk("R9 size_exp", size_exp, e_size);
      chk("R10 done", done, e_done);
    end
  end

  always @(posedge clk) started <= 1'b1;

  // ---------------- stimulus ----------------
  logic [7:0] pkt [64];
  int unsigned lcg = 32'h1234_5678;

  function automatic logic [7:0] rnd8();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg[23:16];
  endfunction

  task automatic build(int rows, int cols, int width, int rcode, int banks, int mask, bit bad);
    int s;
    for (int i = 0; i < 64; i++) pkt[i] = rnd8();
    pkt[3] = 8'(rows); pkt[4] = 8'(cols); pkt[5] = 8'(rnd8() & 8'h0f);
    pkt[6] = 8'(width); pkt[7] = 8'(width >> 8);
    pkt[12] = 8'(rcode); pkt[17] = 8'(banks); pkt[18] = 8'(mask);
    s = 0;
    for (int i = 0; i < 63; i++) s += pkt[i];
    pkt[63] = 8'(s) ^ (bad ? 8'h01 : 8'h00);
  endtask

  task automatic send(int last, int gap);
    for (int i = 0; i <= last; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_index = 6'(i); in_byte = pkt[i];
      if (gap != 0 && (i % gap) == gap - 1) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    vectors++;
    if (row_bits !== 0 || size_exp !== 0 || done !== 0 || cksum_err !== 0 || width_warn !== 0 || in_ready !== 0) begin
      miscompares++;
      $display("FAIL R12 reset state actual=%0d expected=0", {row_bits, size_exp, done, cksum_err, width_warn, in_ready});
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    build(13, 10, 72, 8'h80, 4, 8'h06, 0);  send(63, 0);   // nominal, MSB of refresh masked
    build(15, 12, 80, 5, 8, 8'h01, 1);      send(63, 5);   // clamps, warn, bad checksum, CAS 1 -> 2
    build(12, 9, 64, 9, 3, 8'h00, 0);       send(63, 7);   // empty mask -> 3, odd banks pass through
    for (int k = 0; k < 8; k++) begin
      build(11 + k % 5, 8 + k % 5, (k % 2) ? 64 : 72, k, 1 << (k % 4), 1 << (k % 3), bit'(k % 2));
      send(63, k % 4);
    end
    // R11: truncated record: restart clears, no done
    build(13, 10, 72, 2, 4, 8'h04, 0);
    send(40, 0);
    vectors++;
    if (cksum_err !== 0 || row_bits !== 0 || done !== 0) begin
      miscompares++;
      $display("FAIL R11 truncated record actual=%0d expected=0", {cksum_err, row_bits, done});
    end
    // R11: record without CAS byte after restart
    build(13, 10, 72, 3, 2, 8'h02, 0);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      in_valid = (i != 18); in_index = 6'(i); in_byte = pkt[i];
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (4) @(negedge clk);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule